// File: doc/BRIEF.md
# DMA Channel Register File and Interrupt Collector

This block is the register file for a DMA controller with up to sixteen channels. A simple 32-bit bus writes and reads it. For every channel it keeps a configuration bank: start address, X count, Y count, a control word and a line stride ("width") word. Its global registers cover channel termination, sticky interrupt status, interrupt enable and loop control. The engines that move the data sit outside the block. They take their configuration from the flattened per-channel outputs and react to three strobes: start, stop and loop-enable.

Software programs the count, width and control registers of a channel first and writes the address register last. That final write latches the address and pulses the channel's start strobe. Each engine reports its events (transfer done, half of a loop buffer reached) on a per-channel event line. These events set sticky status bits. The combined interrupt output is high while any status bit is set whose enable bit is also set. Enable and loop control each have a second address that clears bits, so software can clear selected bits without a read-modify-write.

The bus is a plain single-cycle register port with no valid/ready handshake. A write takes effect at the clock edge where `bus_wr` is high. Read data is combinational from `bus_addr`. Bits 1:0 of the address are ignored.

Top module: `dmar_regfile`

## Requirements
- R1: After reset every register, the status, enable and loop bits, `irq`, `ch_start`, `ch_stop` and `ch_loop_en` are all zero.
- R2: For channel n, the X count sits at byte offset n*0x10+0x4, the Y count at n*0x10+0x8 and the control word at n*0x10+0xC. Each of these reads back the last value written and drives the matching `ch_xlen`/`ch_ylen`/`ch_ctrl` slice.
- R3: The width word of channel n sits at 0x100+4n. It reads back the last value written and drives slice n of `ch_width`.
- R4: A write to the address register at n*0x10+0x0 latches the value on slice n of `ch_addr`. It also raises `ch_start[n]` alone for exactly the one cycle after that write edge.
- R5: A read of the address register of channel n returns slice n of `ch_live_addr`, not the value last written.
- R6: Status (0x144) bit n is set by `ch_evt[n]` at the next edge and stays set. Writing a 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R7: When an event and a write-1-to-clear hit the same status bit at the same edge, the bit ends up set.
- R8: A write to the enable register (0x148) replaces all of it. A write to its clear alias (0x14C) clears exactly the enable bits written as 1, and the clear alias reads as zero.
- R9: `irq` is high exactly when some channel has both its status bit and its enable bit set.
- R10: Loop control (0x150) holds bits n and n+16 for each channel and reads back. `ch_loop_en[n]` is high only when both of those bits are set. A write to the clear alias (0x15C) clears exactly the bits written as 1, and the alias reads as zero.
- R11: A write to the terminate register (0x140) raises `ch_stop[n]` for one cycle for each bit n written as 1. The register reads as zero.
- R12: Reads of unmapped offsets (for example 0x154, 0x158, 0x160 and up) return zero. Writes to them change no register and no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | AW (9) | Byte offset |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Read data for bus_addr, combinational |
| ch_evt | input | NCH (16) | Per-channel event pulses from the engines |
| ch_live_addr | input | NCH*DW | Current address of each engine, channel n at slice n |
| ch_addr | output | NCH*DW | Programmed start address per channel |
| ch_xlen | output | NCH*DW | X count per channel |
| ch_ylen | output | NCH*DW | Y count per channel |
| ch_ctrl | output | NCH*DW | Control word per channel |
| ch_width | output | NCH*DW | Line stride word per channel |
| ch_start | output | NCH | One-cycle start strobe per channel |
| ch_stop | output | NCH | One-cycle terminate strobe per channel |
| ch_loop_en | output | NCH | Loop enable per channel |
| irq | output | 1 | Combined interrupt |

## Verification
The bench targets the collision of an engine event with a software clear on the same status bit. A design that let the clear win would drop an interrupt, and status would then read zero where the event should have left a one. It also checks the loop clear alias with only one of a channel's two bits written. Here a design that used one bit per channel would keep `ch_loop_en` high, or would clear a neighbouring channel. Further checks confirm that the address read returns the engine's live value and not a stored copy, and that the start strobe appears only after an address write, never after a count or width write. Random write-clears and enable changes run against a bench model, so `irq` is compared in every cycle with the status/enable intersection.

// File: rtl/dmar_pkg.sv
package dmar_pkg;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_ADDR, SEL_XLEN, SEL_YLEN, SEL_CTRL, SEL_WIDTH,
    SEL_STOP, SEL_STAT, SEL_IEN, SEL_IEN_CLR, SEL_LOOP, SEL_LOOP_CLR
  } sel_e;

  typedef struct packed {
    sel_e       sel;
    logic [3:0] ch;
  } dec_t;

  // Upper half of loop control starts at a fixed bit position.
  localparam int LOOP_HI = 16;

  function automatic logic [31:0] loop_mask(input int nch);
    logic [31:0] m;
    m = '0;
    for (int i = 0; i < nch; i++) begin
      m[i] = 1'b1;
      m[LOOP_HI + i] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/dmar_decode.sv
module dmar_decode
  import dmar_pkg::*;
#(
  parameter int NCH = 16,
  parameter int WAW = 7
) (
  input  logic [WAW-1:0] waddr,
  output dec_t           dec
);
  localparam int BANK_END  = 16 * 4;      // word offset 0x40 (byte 0x100)
  localparam int WIDTH_END = BANK_END + 16; // word offset 0x50 (byte 0x140)

  always_comb begin
    dec.sel = SEL_NONE;
    dec.ch  = '0;
    if (int'(waddr) < BANK_END) begin
      dec.ch = waddr[5:2];
      if (int'(waddr[5:2]) < NCH) begin
        case (waddr[1:0])
          2'd0: dec.sel = SEL_ADDR;
          2'd1: dec.sel = SEL_XLEN;
          2'd2: dec.sel = SEL_YLEN;
          default: dec.sel = SEL_CTRL;
        endcase
      end
    end else if (int'(waddr) < WIDTH_END) begin
      dec.ch = waddr[3:0];
      if (int'(waddr[3:0]) < NCH) dec.sel = SEL_WIDTH;
    end else begin
      case (int'(waddr))
        WIDTH_END + 0: dec.sel = SEL_STOP;
        WIDTH_END + 1: dec.sel = SEL_STAT;
        WIDTH_END + 2: dec.sel = SEL_IEN;
        WIDTH_END + 3: dec.sel = SEL_IEN_CLR;
        WIDTH_END + 4: dec.sel = SEL_LOOP;
        WIDTH_END + 7: dec.sel = SEL_LOOP_CLR;
        default:       dec.sel = SEL_NONE;
      endcase
    end
  end
endmodule

// File: rtl/dmar_chan_bank.sv
module dmar_chan_bank
  import dmar_pkg::*;
#(
  parameter int NCH = 16,
  parameter int DW  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  dec_t              dec,
  input  logic [DW-1:0]     wdata,
  input  logic [NCH*DW-1:0] live_addr,
  output logic [NCH*DW-1:0] cfg_addr,
  output logic [NCH*DW-1:0] cfg_xlen,
  output logic [NCH*DW-1:0] cfg_ylen,
  output logic [NCH*DW-1:0] cfg_ctrl,
  output logic [NCH*DW-1:0] cfg_width,
  output logic [NCH-1:0]    start,
  output logic [DW-1:0]     rdata
);
  logic [DW-1:0] addr_q  [NCH];
  logic [DW-1:0] xlen_q  [NCH];
  logic [DW-1:0] ylen_q  [NCH];
  logic [DW-1:0] ctrl_q  [NCH];
  logic [DW-1:0] width_q [NCH];
  logic [DW-1:0] live    [NCH];
  logic [NCH-1:0] start_q;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic hit;
    assign hit = wr && (int'(dec.ch) == g);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        addr_q[g]  <= '0;
        xlen_q[g]  <= '0;
        ylen_q[g]  <= '0;
        ctrl_q[g]  <= '0;
        width_q[g] <= '0;
        start_q[g] <= 1'b0;
      end else begin
        start_q[g] <= hit && (dec.sel == SEL_ADDR);
        if (hit) begin
          case (dec.sel)
            SEL_ADDR:  addr_q[g]  <= wdata;
            SEL_XLEN:  xlen_q[g]  <= wdata;
            SEL_YLEN:  ylen_q[g]  <= wdata;
            SEL_CTRL:  ctrl_q[g]  <= wdata;
            SEL_WIDTH: width_q[g] <= wdata;
            default: ;
          endcase
        end
      end
    end

    assign live[g]                = live_addr[g*DW +: DW];
    assign cfg_addr[g*DW +: DW]  = addr_q[g];
    assign cfg_xlen[g*DW +: DW]  = xlen_q[g];
    assign cfg_ylen[g*DW +: DW]  = ylen_q[g];
    assign cfg_ctrl[g*DW +: DW]  = ctrl_q[g];
    assign cfg_width[g*DW +: DW] = width_q[g];
  end

  assign start = start_q;

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NCH; i++) begin
      if (int'(dec.ch) == i) begin
        case (dec.sel)
          SEL_ADDR:  rdata = live[i];
          SEL_XLEN:  rdata = xlen_q[i];
          SEL_YLEN:  rdata = ylen_q[i];
          SEL_CTRL:  rdata = ctrl_q[i];
          SEL_WIDTH: rdata = width_q[i];
          default:   rdata = '0;
        endcase
      end
    end
  end

  AST_START_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(start_q)); // R4
  AST_START_AFTER_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && dec.sel == SEL_ADDR) |=> $onehot(start_q)); // R4
  AST_NO_START_OTHER: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr || dec.sel != SEL_ADDR) |=> (start_q == '0)); // R4
endmodule

// File: rtl/dmar_irq.sv
module dmar_irq
  import dmar_pkg::*;
#(
  parameter int NCH = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr,
  input  dec_t           dec,
  input  logic [NCH-1:0] wbits,
  input  logic [NCH-1:0] evt,
  output logic           irq,
  output logic [NCH-1:0] rdata
);
  logic [NCH-1:0] stat_q, en_q, clr;

  assign clr = (wr && dec.sel == SEL_STAT) ? wbits : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= '0;
      en_q   <= '0;
    end else begin
      stat_q <= (stat_q & ~clr) | evt;
      if (wr && dec.sel == SEL_IEN)          en_q <= wbits;
      else if (wr && dec.sel == SEL_IEN_CLR) en_q <= en_q & ~wbits;
    end
  end

  assign irq = |(stat_q & en_q);

  always_comb begin
    case (dec.sel)
      SEL_STAT: rdata = stat_q;
      SEL_IEN:  rdata = en_q;
      default:  rdata = '0;
    endcase
  end

  AST_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> ((stat_q & $past(evt)) == $past(evt))); // R7
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr != '0) |=> ((stat_q & $past(clr & ~evt)) == '0)); // R6
  AST_STAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & $past(stat_q & ~clr)) == $past(stat_q & ~clr))); // R6
  AST_ENCLR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && dec.sel == SEL_IEN_CLR) |=>
      ((en_q & ~$past(wbits)) == ($past(en_q) & ~$past(wbits)))); // R8
endmodule

// File: rtl/dmar_loop.sv
module dmar_loop
  import dmar_pkg::*;
#(
  parameter int NCH = 16,
  parameter int DW  = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr,
  input  dec_t           dec,
  input  logic [DW-1:0]  wdata,
  output logic [NCH-1:0] loop_en,
  output logic [NCH-1:0] stop,
  output logic [DW-1:0]  rdata
);
  localparam logic [31:0] MASK = loop_mask(NCH);

  logic [31:0]    lc_q;
  logic [NCH-1:0] stop_q;
  logic [NCH-1:0] clr_ch;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lc_q   <= '0;
      stop_q <= '0;
    end else begin
      stop_q <= (wr && dec.sel == SEL_STOP) ? wdata[NCH-1:0] : '0;
      if (wr && dec.sel == SEL_LOOP)          lc_q <= wdata[31:0] & MASK;
      else if (wr && dec.sel == SEL_LOOP_CLR) lc_q <= lc_q & ~wdata[31:0];
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_le
    assign loop_en[g] = lc_q[g] & lc_q[LOOP_HI + g];
    assign clr_ch[g]  = wdata[g] | wdata[LOOP_HI + g];
  end

  assign stop  = stop_q;
  assign rdata = (dec.sel == SEL_LOOP) ? DW'(lc_q) : '0;

  AST_LOOP_CLR_PAUSES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && dec.sel == SEL_LOOP_CLR) |=> ((loop_en & $past(clr_ch)) == '0)); // R10
  AST_STOP_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr || dec.sel != SEL_STOP) |=> (stop_q == '0)); // R11
endmodule

// File: rtl/dmar_regfile.sv
module dmar_regfile
  import dmar_pkg::*;
#(
  parameter int NCH = 16,
  parameter int DW  = 32,
  parameter int AW  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic [NCH-1:0]    ch_evt,
  input  logic [NCH*DW-1:0] ch_live_addr,
  output logic [NCH*DW-1:0] ch_addr,
  output logic [NCH*DW-1:0] ch_xlen,
  output logic [NCH*DW-1:0] ch_ylen,
  output logic [NCH*DW-1:0] ch_ctrl,
  output logic [NCH*DW-1:0] ch_width,
  output logic [NCH-1:0]    ch_start,
  output logic [NCH-1:0]    ch_stop,
  output logic [NCH-1:0]    ch_loop_en,
  output logic              irq
);
  localparam int WAW = AW - 2;

  dec_t           dec;
  logic [DW-1:0]  rd_bank, rd_loop;
  logic [NCH-1:0] rd_irq;

  dmar_decode #(.NCH(NCH), .WAW(WAW)) u_dec (
    .waddr (bus_addr[AW-1:2]),
    .dec   (dec)
  );

  dmar_chan_bank #(.NCH(NCH), .DW(DW)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr        (bus_wr),
    .dec       (dec),
    .wdata     (bus_wdata),
    .live_addr (ch_live_addr),
    .cfg_addr  (ch_addr),
    .cfg_xlen  (ch_xlen),
    .cfg_ylen  (ch_ylen),
    .cfg_ctrl  (ch_ctrl),
    .cfg_width (ch_width),
    .start     (ch_start),
    .rdata     (rd_bank)
  );

  dmar_irq #(.NCH(NCH)) u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (bus_wr),
    .dec   (dec),
    .wbits (bus_wdata[NCH-1:0]),
    .evt   (ch_evt),
    .irq   (irq),
    .rdata (rd_irq)
  );

  dmar_loop #(.NCH(NCH), .DW(DW)) u_loop (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (bus_wr),
    .dec     (dec),
    .wdata   (bus_wdata),
    .loop_en (ch_loop_en),
    .stop    (ch_stop),
    .rdata   (rd_loop)
  );

  assign bus_rdata = rd_bank | DW'(rd_irq) | rd_loop;

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (dec.sel == SEL_NONE) |-> (bus_rdata == '0)); // R12
  AST_UNMAPPED_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && dec.sel == SEL_NONE) |=> (ch_start == '0 && ch_stop == '0)); // R12
endmodule

// File: tb/sim_dmar_regfile.sv
module sim_dmar_regfile;
  localparam int NCH = 16;
  localparam int DW  = 32;
  localparam int AW  = 9;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              bus_wr = 1'b0;
  logic [AW-1:0]     bus_addr = '0;
  logic [DW-1:0]     bus_wdata = '0;
  logic [DW-1:0]     bus_rdata;
  logic [NCH-1:0]    ch_evt = '0;
  logic [NCH*DW-1:0] ch_live_addr;
  logic [NCH*DW-1:0] ch_addr, ch_xlen, ch_ylen, ch_ctrl, ch_width;
  logic [NCH-1:0]    ch_start, ch_stop, ch_loop_en;
  logic              irq;

  int n_chk = 0;
  int n_fail = 0;
  logic [NCH-1:0] m_stat = '0, m_en = '0;
  logic [31:0]    m_lc = '0;
  logic [NCH-1:0] got_start, got_stop;

  always #10 clk = ~clk;

  for (genvar g = 0; g < NCH; g++) begin : g_live
    assign ch_live_addr[g*DW +: DW] = 32'hA500_0000 + 32'(g) * 32'h0001_0101;
  end

  dmar_regfile #(.NCH(NCH), .DW(DW), .AW(AW)) u0 (.*);

  function automatic logic [NCH-1:0] exp_loop_en(input logic [31:0] lc);
    logic [NCH-1:0] r;
    for (int i = 0; i < NCH; i++) r[i] = lc[i] & lc[16 + i];
    return r;
  endfunction

  function automatic logic [31:0] live_of(input int ch);
    return 32'hA500_0000 + 32'(ch) * 32'h0001_0101;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One bus cycle with optional event; captures the strobes after the edge.
  task automatic cyc(input bit wr, input logic [AW-1:0] a, input logic [31:0] d,
                     input logic [NCH-1:0] evt);
    @(negedge clk);
    bus_wr = wr; bus_addr = a; bus_wdata = d; ch_evt = evt;
    @(negedge clk);
    got_start = ch_start; got_stop = ch_stop;
    bus_wr = 1'b0; ch_evt = '0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  initial begin : watchdog
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    logic [31:0] v, d;
    void'($urandom(32'h0000_5EED));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(irq == 1'b0 && ch_start == '0 && ch_stop == '0 && ch_loop_en == '0,
        "R1", {irq, ch_start, ch_stop[14:0]}, 32'h0);
    rd(9'h144, v); chk(v == 0, "R1 status", v, 0);
    rd(9'h150, v); chk(v == 0, "R1 loop", v, 0);
    rd(9'h034, v); chk(v == 0, "R1 xlen", v, 0);

    // R2 R3 bank and width, no start strobe
    for (int c = 0; c < NCH; c++) begin
      cyc(1, 9'(c*16 + 4), 32'h1000 + c, '0);
      chk(got_start == '0, "R4 no start on xlen", got_start, 0);
      cyc(1, 9'(c*16 + 8), 32'h2000 + c, '0);
      cyc(1, 9'(c*16 + 12), 32'h3000 + c, '0);
      cyc(1, 9'(256 + c*4), 32'h4000 + c, '0);
      chk(got_start == '0, "R4 no start on width", got_start, 0);
    end
    for (int c = 0; c < NCH; c++) begin
      rd(9'(c*16 + 4), v);  chk(v == 32'h1000 + c, "R2 xlen", v, 32'h1000 + c);
      rd(9'(c*16 + 8), v);  chk(v == 32'h2000 + c, "R2 ylen", v, 32'h2000 + c);
      rd(9'(c*16 + 12), v); chk(v == 32'h3000 + c, "R2 ctrl", v, 32'h3000 + c);
      rd(9'(256 + c*4), v); chk(v == 32'h4000 + c, "R3 width", v, 32'h4000 + c);
      chk(ch_xlen[c*DW +: DW] == 32'h1000 + c, "R2 xlen out", ch_xlen[c*DW +: DW], 32'h1000 + c);
      chk(ch_width[c*DW +: DW] == 32'h4000 + c, "R3 width out", ch_width[c*DW +: DW], 32'h4000 + c);
    end

    // R4 R5 address write starts channel; read returns live address
    for (int c = 0; c < NCH; c += 5) begin
      cyc(1, 9'(c*16), 32'hC0DE_0000 + c, '0);
      chk(got_start == NCH'(1) << c, "R4 start", got_start, NCH'(1) << c);
      chk(ch_addr[c*DW +: DW] == 32'hC0DE_0000 + c, "R4 addr out",
          ch_addr[c*DW +: DW], 32'hC0DE_0000 + c);
      @(negedge clk);
      chk(ch_start == '0, "R4 start one cycle", ch_start, 0);
      rd(9'(c*16), v); chk(v == live_of(c), "R5 live read", v, live_of(c));
    end

    // R11 terminate strobes
    cyc(1, 9'h140, 32'h0000_8421, '0);
    chk(got_stop == 16'h8421, "R11 stop", got_stop, 16'h8421);
    @(negedge clk);
    chk(ch_stop == '0, "R11 stop one cycle", ch_stop, 0);
    rd(9'h140, v); chk(v == 0, "R11 read zero", v, 0);

    // R6 R7 directed: event and clear on same bit
    cyc(1, 9'h148, 32'h0000_0005, '0); m_en = 16'h0005;
    cyc(0, 9'h0, 0, 16'h0005); m_stat = 16'h0005;
    chk(irq == 1'b1, "R9 irq set", irq, 1);
    cyc(1, 9'h144, 32'h0000_0005, 16'h0001); m_stat = 16'h0001;
    rd(9'h144, v); chk(v == 32'h1, "R7 event wins", v, 1);
    cyc(1, 9'h144, 32'h0000_0000, '0);
    rd(9'h144, v); chk(v == 32'h1, "R6 write zero keeps", v, 1);
    cyc(1, 9'h14C, 32'h0000_0001, '0); m_en = 16'h0004;
    rd(9'h148, v); chk(v == 32'h4, "R8 enable clear", v, 4);
    rd(9'h14C, v); chk(v == 0, "R8 clear alias reads zero", v, 0);
    chk(irq == 1'b0, "R9 irq masked", irq, 0);

    // R10 loop control
    cyc(1, 9'h150, 32'h0003_0007, '0); m_lc = 32'h0003_0007;
    chk(ch_loop_en == 16'h0003, "R10 loop both bits", ch_loop_en, 3);
    rd(9'h150, v); chk(v == 32'h0003_0007, "R10 loop read", v, 32'h0003_0007);
    cyc(1, 9'h15C, 32'h0002_0000, '0); m_lc = 32'h0001_0007;
    chk(ch_loop_en == 16'h0001, "R10 clear high bit pauses", ch_loop_en, 1);
    rd(9'h150, v); chk(v == m_lc, "R10 clear exact", v, m_lc);
    rd(9'h15C, v); chk(v == 0, "R10 alias reads zero", v, 0);

    // R12 unmapped
    cyc(1, 9'h154, 32'hFFFF_FFFF, '0);
    chk(got_start == '0 && got_stop == '0, "R12 no strobe", {got_start, got_stop}, 0);
    cyc(1, 9'h1FC, 32'hFFFF_FFFF, '0);
    rd(9'h154, v); chk(v == 0, "R12 read 0x154", v, 0);
    rd(9'h158, v); chk(v == 0, "R12 read 0x158", v, 0);
    rd(9'h160, v); chk(v == 0, "R12 read 0x160", v, 0);
    rd(9'h150, v); chk(v == m_lc, "R12 loop untouched", v, m_lc);
    rd(9'h148, v); chk(v == 32'(m_en), "R12 enable untouched", v, 32'(m_en));
    rd(9'h144, v); chk(v == 32'(m_stat), "R12 status untouched", v, 32'(m_stat));

    // Random mix: status clears, enable writes and clears, loop writes, events
    for (int it = 0; it < 600; it++) begin
      logic [NCH-1:0] e;
      int op;
      e  = NCH'($urandom & $urandom);
      d  = $urandom;
      op = int'($urandom_range(0, 4));
      case (op)
        0: begin cyc(1, 9'h144, d, e); m_stat = (m_stat & ~d[NCH-1:0]) | e; end
        1: begin cyc(1, 9'h148, d, e); m_en = d[NCH-1:0]; m_stat |= e; end
        2: begin cyc(1, 9'h14C, d, e); m_en &= ~d[NCH-1:0]; m_stat |= e; end
        3: begin cyc(1, 9'h150, d, e); m_lc = d; m_stat |= e; end
        default: begin cyc(1, 9'h15C, d, e); m_lc &= ~d; m_stat |= e; end
      endcase
      chk(irq == |(m_stat & m_en), "R9 irq", irq, |(m_stat & m_en));
      chk(ch_loop_en == exp_loop_en(m_lc), "R10 loop_en", ch_loop_en, exp_loop_en(m_lc));
      rd(9'h144, v); chk(v == 32'(m_stat), "R6 status", v, 32'(m_stat));
      rd(9'h148, v); chk(v == 32'(m_en), "R8 enable", v, 32'(m_en));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule